// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses at fetch time whether a conditional branch will be taken. It keeps a shift register of recent branch directions across the whole program. It forms a table index by XOR-ing that history with the word address of the branch, and it reads a 2-bit saturating counter at that index. The upper bit of the counter is the guess. The current history is also driven out, so that the fetch side can carry it along with the branch as a snapshot.

When the branch resolves, the back end returns the branch address, the real direction, the snapshot taken at prediction and a mispredict flag. The counter addressed by snapshot XOR address then trains toward the real direction. A fetch lookup shifts the guessed direction into the history straight away. A mispredicted resolution rebuilds the history from the snapshot, with the real direction appended.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history reads all zeros and every counter holds 01 (weakly not-taken), so every address predicts not-taken.
- R2: predTaken is combinational and equals bit 1 of the counter at index histSnap XOR lookupPc[HIST_W+1:2]. It is valid whether or not lookupValid is high.
- R3: Address bits 1:0 never affect the index, on either the lookup side or the update side.
- R4: An update with updTaken=1 adds one to the counter at its index, and the counter stops at 3.
- R5: An update with updTaken=0 subtracts one from the counter at its index, and the counter stops at 0.
- R6: The update index is updHist XOR updPc[HIST_W+1:2]. The live history plays no part in it.
- R7: On a clock edge with lookupValid=1, the history shifts left by one and predTaken enters at bit 0. The oldest bit is lost.
- R8: On a clock edge with updValid=1 and updMispredict=1, the history becomes {updHist[HIST_W-2:0], updTaken}. This takes priority over a lookup in the same cycle.
- R9: The history does not change on an edge with no lookup and no mispredicted update. An update that was predicted correctly leaves the history alone.
- R10: When a lookup and an update address the same counter in the same cycle, predTaken shows the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A branch is fetched this cycle, so shift the guess into the history |
| lookupPc | input | PC_W | Address of the branch being fetched |
| predTaken | output | 1 | Guessed direction, 1 = taken |
| histSnap | output | HIST_W | Current global history, the snapshot the fetch side keeps |
| updValid | input | 1 | A branch resolves this cycle |
| updPc | input | PC_W | Address of the resolving branch |
| updTaken | input | 1 | Real direction of the resolving branch |
| updMispredict | input | 1 | The earlier guess was wrong, so rebuild the history |
| updHist | input | HIST_W | Snapshot that was taken when the resolving branch was predicted |

## Verification
The bench builds the block with HIST_W=4 and PC_W=8. That gives a table of only 16 counters, and any history value can be reached in at most four lookups. At this size a sweep of the lookup address reads back every counter, and a long mixed sequence of lookups and updates can be compared against an arithmetic model at every cycle. The saturation limits, the XOR aliasing between history and address, and the read-before-write behaviour on a shared index can each be reached in a few cycles.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

  typedef struct packed {
    logic specShift;
    logic restore;
    logic train;
  } gsCtrl_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else    nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
  import gsp_pkg::*;
(
  input  logic    lookupValid,
  input  logic    updValid,
  input  logic    updMispredict,
  output gsCtrl_t ctrl
);
  always_comb begin
    ctrl.restore   = updValid & updMispredict;
    ctrl.specShift = lookupValid & ~ctrl.restore;
    ctrl.train     = updValid;
  end
endmodule

// File: rtl/gsp_datapath.sv
module gsp_datapath
  import gsp_pkg::*;
#(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gsCtrl_t           ctrl,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updHist,
  output logic              predTaken,
  output logic [HIST_W-1:0] histSnap
);
  localparam int ENTRIES = 1 << HIST_W;

  logic [HIST_W-1:0] histQ;
  logic [HIST_W-1:0] lookIdx;
  logic [HIST_W-1:0] updIdx;
  logic [1:0]        ctrTab [ENTRIES];

  // word-aligned addresses: drop bits 1:0 before hashing
  assign lookIdx   = histQ ^ lookupPc[HIST_W+1:2];
  assign updIdx    = updHist ^ updPc[HIST_W+1:2];
  assign predTaken = ctrTab[lookIdx][1];
  assign histSnap  = histQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              histQ <= '0;
    else if (ctrl.restore)   histQ <= {updHist[HIST_W-2:0], updTaken};
    else if (ctrl.specShift) histQ <= {histQ[HIST_W-2:0], predTaken};
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
    logic hitUpd;
    assign hitUpd = ctrl.train && (updIdx == HIST_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrTab[e] <= 2'b01;
      else if (hitUpd) ctrTab[e] <= satStep(ctrTab[e], updTaken);
    end
  end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gsp_pkg::*;
#(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              predTaken,
  output logic [HIST_W-1:0] histSnap,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  input  logic              updMispredict,
  input  logic [HIST_W-1:0] updHist
);
  gsCtrl_t ctrl;

  gsp_ctrl u_ctrl (
    .lookupValid  (lookupValid),
    .updValid     (updValid),
    .updMispredict(updMispredict),
    .ctrl         (ctrl)
  );

  gsp_datapath #(.HIST_W(HIST_W), .PC_W(PC_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .lookupPc (lookupPc),
    .updPc    (updPc),
    .updTaken (updTaken),
    .updHist  (updHist),
    .predTaken(predTaken),
    .histSnap (histSnap)
  );
endmodule

// File: rtl/gshare_chk.sv
module gshare_chk #(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lookupValid,
  input logic [PC_W-1:0]   lookupPc,
  input logic              predTaken,
  input logic [HIST_W-1:0] histSnap,
  input logic              updValid,
  input logic [PC_W-1:0]   updPc,
  input logic              updTaken,
  input logic              updMispredict,
  input logic [HIST_W-1:0] updHist
);
  // R1
  reset_hist_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> histSnap == '0);

  // R7
  spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && !(updValid && updMispredict)) |=>
      histSnap == {$past(histSnap[HIST_W-2:0]), $past(predTaken)});

  // R8
  restore_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updMispredict) |=>
      histSnap == {$past(updHist[HIST_W-2:0]), $past(updTaken)});

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lookupValid && !(updValid && updMispredict)) |=> $stable(histSnap));
endmodule

bind gshare_predictor gshare_chk #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/sim_gshare_predictor.sv
`timescale 1ns/1ps
module sim_gshare_predictor;
  localparam int HW = 4;
  localparam int PW = 8;
  localparam int N  = 1 << HW;

  logic clk = 0;
  logic rst_n = 0;
  logic lookupValid = 0;
  logic [PW-1:0] lookupPc = '0;
  logic predTaken;
  logic [HW-1:0] histSnap;
  logic updValid = 0;
  logic [PW-1:0] updPc = '0;
  logic updTaken = 0;
  logic updMispredict = 0;
  logic [HW-1:0] updHist = '0;

  int nTests = 0;
  int nFail = 0;
  int mCtr [N];
  int mHist = 0;

  always #2.5 clk = ~clk;

  gshare_predictor #(.HIST_W(HW), .PC_W(PW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mPred(input int pc);
    return (mCtr[(mHist ^ (pc >> 2)) & (N-1)] >= 2) ? 1 : 0;
  endfunction

  // checks predTaken before the edge, advances model, checks history after
  task automatic cycle(input string req);
    int p, ui;
    #0.5;
    p = mPred(int'(lookupPc));
    chk({req, " pred"}, int'(predTaken), p);
    ui = (int'(updHist) ^ (int'(updPc) >> 2)) & (N-1);
    if (updValid && updMispredict)
      mHist = ((int'(updHist) << 1) | int'(updTaken)) & (N-1);
    else if (lookupValid)
      mHist = ((mHist << 1) | p) & (N-1);
    if (updValid) begin
      if (updTaken && mCtr[ui] < 3) mCtr[ui]++;
      if (!updTaken && mCtr[ui] > 0) mCtr[ui]--;
    end
    @(posedge clk); #1;
    chk({req, " hist"}, int'(histSnap), mHist);
  endtask

  task automatic idle();
    lookupValid = 0; updValid = 0; updMispredict = 0; updTaken = 0;
  endtask

  task automatic upd(input int pc, input int tk, input int h, input int mp, input string req);
    updValid = 1; updPc = PW'(pc); updTaken = tk[0]; updHist = HW'(h); updMispredict = mp[0];
    cycle(req);
    idle();
  endtask

  task automatic readAll(input string req);
    for (int k = 0; k < N; k++) begin
      lookupPc = PW'(k << 2); #0.5;
      chk(req, int'(predTaken), mPred(k << 2));
    end
  endtask

  initial begin
    #(200000 * 5);
    nFail++; nTests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int saved;
    for (int i = 0; i < N; i++) mCtr[i] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1: reset state, all predict not-taken
    chk("R1 hist", int'(histSnap), 0);
    readAll("R1 R2 reset pred");
    for (int k = 0; k < N; k++) begin
      lookupPc = PW'(k << 2); #0.5; chk("R1 exact", int'(predTaken), 0);
    end

    // R4: train up to saturation, one not-taken still taken
    for (int i = 0; i < 5; i++) upd(5 << 2, 1, 0, 0, "R4 train up");
    lookupPc = PW'(5 << 2); #0.5; chk("R4 sat3", int'(predTaken), 1);
    upd(5 << 2, 0, 0, 0, "R4 after sat");
    #0.5; chk("R4 hysteresis", int'(predTaken), 1);
    // R5: down to saturation, one taken still not-taken
    for (int i = 0; i < 6; i++) upd(5 << 2, 0, 0, 0, "R5 train down");
    upd(5 << 2, 1, 0, 0, "R5 after sat");
    lookupPc = PW'(5 << 2); #0.5; chk("R5 sat0", int'(predTaken), 0);

    // R6: update index from snapshot, not live history
    upd(1 << 2, 1, 3, 0, "R6 upd");
    upd(1 << 2, 1, 3, 0, "R6 upd");
    lookupPc = PW'(2 << 2); #0.5; chk("R6 aliased entry", int'(predTaken), 1);
    lookupPc = PW'(1 << 2); #0.5; chk("R6 own entry untouched", int'(predTaken), 0);
    // R3: low address bits ignored
    lookupPc = PW'((2 << 2) | 3); #0.5; chk("R3 lookup low bits", int'(predTaken), 1);
    upd((7 << 2) | 2, 1, 0, 0, "R3 upd");
    upd((7 << 2) | 1, 1, 0, 0, "R3 upd");
    lookupPc = PW'(7 << 2); #0.5; chk("R3 update low bits", int'(predTaken), 1);

    // R7: speculative shifts
    lookupValid = 1;
    lookupPc = PW'(2 << 2); cycle("R7 shift");
    for (int i = 0; i < 6; i++) begin lookupPc = PW'(i << 2); cycle("R7 shift"); end
    idle();
    // R9: correct-path update and idle leave history
    saved = int'(histSnap);
    upd(3 << 2, 1, 9, 0, "R9 no-restore update");
    chk("R9 hist kept", int'(histSnap), saved);
    cycle("R9 idle");
    // R8: restore beats concurrent lookup
    lookupValid = 1; lookupPc = PW'(4 << 2);
    upd(4 << 2, 1, 10, 1, "R8 restore");
    chk("R8 restored", int'(histSnap), 5);
    // R10: same-entry lookup and update, pre-update value returned
    lookupPc = PW'((5 ^ int'(histSnap)) << 2); #0.5;
    saved = int'(predTaken);
    lookupValid = 1;
    upd(5 << 2, 1, 0, 0, "R10 bypass");
    upd(5 << 2, 1, 0, 0, "R10 bypass");
    chk("R10 first saw old", saved, 0);

    // sweep: mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      lookupValid = (i % 3) != 0;
      lookupPc = PW'((i * 37) & 8'hFF);
      updValid = (i % 4) != 1;
      updPc = PW'((i * 11 + 3) & 8'hFF);
      updTaken = ((i * 7) % 5) < 3;
      updHist = HW'(i * 5);
      updMispredict = (i % 9) == 4;
      cycle("R2 R7 sweep");
    end
    idle();
    readAll("R2 sweep readback");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule